// File: doc/BRIEF.md
# Pulse-Width Modulation Channel with Left and Center Alignment

This block generates one pulse-width modulated waveform from an 8-bit counter. A small register write port holds the period, the duty value and a control word. The control word sets enable, polarity, alignment and which of four incoming clock-enable strobes advances the counter. The strobes come from a shared prescaler outside the block. Everything runs on one system clock, and the counter moves only on cycles where the selected strobe is high.

In left-aligned mode the counter runs upward and wraps, so one period lasts `period` strobe ticks. In center-aligned mode it runs up and then back down, so one period lasts `2 × period` ticks and the pulse sits in the middle of the period. The duty value always measures the phase at the level given by the polarity bit. Period and duty writes go to buffers, and the buffered values reach the comparator only at a period boundary or while the channel is disabled.

Top module: `pwm_chan`

## Requirements
- R1: The write port decodes address 0 as the period buffer, 1 as the duty buffer and 2 as control: bit 0 enable, bit 1 polarity, bit 2 center-align, bits 4:3 strobe select. A write to address 3 has no effect.
- R2: The counter advances only on cycles where the channel is enabled and the strobe indexed by the select field is 1; activity on the other three strobes has no effect on the waveform.
- R3: In left-aligned mode the tick index within a period runs 0 … period−1 and then wraps, so one period lasts `period` ticks. With period 4, duty 1 and polarity 0, six of eight consecutive ticks are high.
- R4: The active level equals the polarity bit. For tick index i, the output is active when i < duty and inactive otherwise. With polarity 0 each period therefore starts low and goes high on the duty match. With polarity 1 it starts high and goes low.
- R5: In center-aligned mode one period lasts 2 × period ticks. The counter goes 0 … period−1 and then period−1 … 0, and the output is active while the counter is below duty, so it changes level on the duty match in both directions.
- R6: When duty ≥ period the output stays at the active level for the whole period. When period is 0 the output stays at the active level for as long as the channel is enabled.
- R7: While the channel is enabled, a write to the period or duty buffer reaches the waveform only after the current period ends. While the channel is disabled, the buffers are copied every cycle.
- R8: While disabled, the counter is held at zero and the output rests at the inactive level, the inverse of the polarity bit. After reset the control word is 0, so the output is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select (0 period, 1 duty, 2 control) |
| wr_data_i | input | CW | Write data |
| strb_i | input | 4 | Prescaled clock-enable strobes |
| wave_o | output | 1 | PWM waveform |

## Verification
The assertions check four things on every cycle. The counter never leaves the range set by the active period, and it holds still on cycles without a selected strobe. A disabled channel returns its counter to zero. The active period and duty change only at a counter wrap or while disabled. Duty ratios, the waveform shape in each alignment, the polarity meaning, the deferred effect of buffered writes and the blindness to unselected strobes can only be shown by the bench. The bench sweeps every period from 0 to 5 against every duty from 0 to 6, in both polarities and both alignments, and compares the output on every cycle with a tick-counting model.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned NUM_STRB = 4;
  localparam int unsigned SEL_W    = $clog2(NUM_STRB);
  localparam int unsigned ADDR_W   = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_PER = 2'd0,
    REG_DTY = 2'd1,
    REG_CTL = 2'd2,
    REG_RSV = 2'd3
  } reg_addr_e;

  // control word bit positions
  localparam int unsigned CTL_EN  = 0;
  localparam int unsigned CTL_POL = 1;
  localparam int unsigned CTL_CTR = 2;
  localparam int unsigned CTL_SEL = 3;
  localparam int unsigned CTL_W   = CTL_SEL + SEL_W;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [CW-1:0]     wr_data_i,
  input  logic              wrap_i,
  output logic              en_o,
  output logic              pol_o,
  output logic              ctr_o,
  output logic [SEL_W-1:0]  sel_o,
  output logic [CW-1:0]     per_o,
  output logic [CW-1:0]     dty_o
);
  logic [CW-1:0]    per_buf, dty_buf;
  logic [CTL_W-1:0] ctl_q;
  logic             load;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_buf <= '0;
      dty_buf <= '0;
      ctl_q   <= '0;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(wr_addr_i))
        REG_PER: per_buf <= wr_data_i;
        REG_DTY: dty_buf <= wr_data_i;
        REG_CTL: ctl_q   <= wr_data_i[CTL_W-1:0];
        default: ;
      endcase
    end
  end

  assign en_o  = ctl_q[CTL_EN];
  assign pol_o = ctl_q[CTL_POL];
  assign ctr_o = ctl_q[CTL_CTR];
  assign sel_o = ctl_q[CTL_SEL +: SEL_W];

  // buffers track freely while idle, else only at period end
  assign load = !en_o || wrap_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      per_o <= '0;
      dty_o <= '0;
    end else if (load) begin
      per_o <= per_buf;
      dty_o <= dty_buf;
    end
  end

  // R7
  shadow_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o && !wrap_i) |=> ($stable(per_o) && $stable(dty_o)));
endmodule

// File: rtl/pwm_cnt.sv
module pwm_cnt #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          tick_i,
  input  logic          ctr_i,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] cnt_o,
  output logic          wrap_o
);
  logic          dn_q;
  logic          per_zero, at_top, at_bot;
  logic [CW-1:0] top;

  assign per_zero = (per_i == '0);
  assign top      = per_i - 1'b1;
  assign at_top   = (cnt_o == top);
  assign at_bot   = (cnt_o == '0);

  always_comb begin
    wrap_o = 1'b0;
    if (tick_i) begin
      if (per_zero)   wrap_o = 1'b1;
      else if (!ctr_i) wrap_o = at_top;
      else            wrap_o = dn_q && at_bot;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      dn_q  <= 1'b0;
    end else if (!en_i) begin
      cnt_o <= '0;
      dn_q  <= 1'b0;
    end else if (tick_i) begin
      if (per_zero) begin
        cnt_o <= '0;
        dn_q  <= 1'b0;
      end else if (!ctr_i) begin
        cnt_o <= at_top ? '0 : cnt_o + 1'b1;
        dn_q  <= 1'b0;
      end else if (!dn_q) begin
        // turnaround repeats the top value once
        if (at_top) dn_q  <= 1'b1;
        else        cnt_o <= cnt_o + 1'b1;
      end else begin
        if (at_bot) dn_q  <= 1'b0;
        else        cnt_o <= cnt_o - 1'b1;
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !per_zero) |-> (cnt_o < per_i));

  // R2
  cnt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !tick_i) |=> $stable(cnt_o));

  // R8
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (cnt_o == '0));

  // R5
  center_turn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tick_i && ctr_i && !per_zero && !dn_q && at_top)
      |=> (cnt_o == $past(cnt_o)));
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave #(
  parameter int unsigned CW = 8
) (
  input  logic          en_i,
  input  logic          pol_i,
  input  logic [CW-1:0] per_i,
  input  logic [CW-1:0] dty_i,
  input  logic [CW-1:0] cnt_i,
  output logic          wave_o
);
  logic active;

  // zero period or duty above count: active level
  assign active = (per_i == '0) || (cnt_i < dty_i);
  assign wave_o = en_i ? (active ? pol_i : ~pol_i) : ~pol_i;
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
#(
  parameter int unsigned CW = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [ADDR_W-1:0]   wr_addr_i,
  input  logic [CW-1:0]       wr_data_i,
  input  logic [NUM_STRB-1:0] strb_i,
  output logic                wave_o
);
  logic             en, pol, ctr, wrap, tick;
  logic [SEL_W-1:0] sel;
  logic [CW-1:0]    per, dty, cnt;

  assign tick = en && strb_i[sel];

  pwm_regs #(.CW(CW)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .wrap_i    (wrap),
    .en_o      (en),
    .pol_o     (pol),
    .ctr_o     (ctr),
    .sel_o     (sel),
    .per_o     (per),
    .dty_o     (dty)
  );

  pwm_cnt #(.CW(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .tick_i (tick),
    .ctr_i  (ctr),
    .per_i  (per),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  pwm_wave #(.CW(CW)) u_wave (
    .en_i   (en),
    .pol_i  (pol),
    .per_i  (per),
    .dty_i  (dty),
    .cnt_i  (cnt),
    .wave_o (wave_o)
  );

  // R6
  zero_per_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en && per == '0) |-> (wave_o == pol));
endmodule

// File: tb/pwm_chan_tb.sv
module pwm_chan_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [1:0] wr_addr_i = '0;
  logic [7:0] wr_data_i = '0;
  logic [3:0] strb_i = '0;
  logic       wave_o;

  int checks = 0;
  int errors = 0;
  string tag_ovr = "";

  // reference state
  int   m_per = 0, m_dty = 0, p_per = 0, p_dty = 0, ph = 0;
  logic m_en = 0, m_pol = 0, m_ctr = 0;
  logic [1:0] m_sel = 0;

  always #4 clk = ~clk;

  pwm_chan #(.CW(8)) u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .strb_i    (strb_i),
    .wave_o    (wave_o)
  );

  function automatic int plen();
    if (m_per == 0) return 1;
    return m_ctr ? 2 * m_per : m_per;
  endfunction

  function automatic logic exp_wave();
    int c;
    if (!m_en) return !m_pol;
    if (m_per == 0) return m_pol;
    c = (m_ctr && ph >= m_per) ? 2 * m_per - 1 - ph : ph;
    return (c < m_dty) ? m_pol : !m_pol;
  endfunction

  function automatic string tag();
    if (tag_ovr != "") return tag_ovr;
    if (!m_en) return "R8";
    if (m_per == 0 || m_dty >= m_per) return "R6";
    return m_ctr ? "R5 R4" : "R3 R4";
  endfunction

  task automatic chk(input string t, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", t, act, expv);
    end
  endtask

  // one cycle: check, drive, edge, model update
  task automatic step(input logic we, input logic [1:0] a, input logic [7:0] d, input logic on);
    logic old_en;
    chk(tag(), int'(wave_o), int'(exp_wave()));
    wr_en_i   = we;
    wr_addr_i = a;
    wr_data_i = d;
    strb_i    = 4'($urandom);
    strb_i[m_sel] = on;
    @(posedge clk);
    old_en = m_en;
    if (!old_en) begin
      m_per = p_per; m_dty = p_dty; ph = 0;
    end else if (on) begin
      ph++;
      if (ph >= plen()) begin
        ph = 0; m_per = p_per; m_dty = p_dty;
      end
    end
    if (we) begin
      case (a)
        2'd0: p_per = int'(d);
        2'd1: p_dty = int'(d);
        2'd2: begin m_en = d[0]; m_pol = d[1]; m_ctr = d[2]; m_sel = d[4:3]; end
        default: ;
      endcase
    end
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic cfg(input int per, input int dty, input logic pol, input logic ctr, input logic [1:0] sel);
    logic [7:0] c;
    c = {3'b000, sel, ctr, pol, 1'b0};
    step(1'b1, 2'd2, c, 1'b0);
    step(1'b1, 2'd0, 8'(per), 1'b0);
    step(1'b1, 2'd1, 8'(dty), 1'b0);
    step(1'b1, 2'd2, c | 8'h01, 1'b0);
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int hi, rises;
    logic prev;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 reset", int'(wave_o), 1);

    // R3 worked example: period 4, duty 1, polarity 0
    cfg(4, 1, 1'b0, 1'b0, 2'd0);
    hi = 0; rises = 0; prev = wave_o;
    for (int i = 0; i < 8; i++) begin
      if (wave_o) hi++;
      step(1'b0, 2'd0, 8'd0, 1'b1);
      if (wave_o && !prev) rises++;
      prev = wave_o;
    end
    chk("R3 high ticks of 8", hi, 6);
    chk("R3 rising edges", rises, 2);

    // full sweep over small configurations
    for (int pol = 0; pol < 2; pol++)
      for (int ctr = 0; ctr < 2; ctr++)
        for (int per = 0; per < 6; per++)
          for (int dty = 0; dty < 7; dty++) begin
            logic [1:0] s;
            s = 2'((per + dty + ctr) % 4);
            cfg(per, dty, pol[0], ctr[0], s);
            for (int k = 0; k < 3 * 2 * (per + 1) * 2; k++)
              step(1'b0, 2'd0, 8'd0, s[0] ? k[0] : 1'b1);
          end

    // R2 only unselected strobes toggle
    cfg(5, 2, 1'b1, 1'b0, 2'd2);
    step(1'b0, 2'd0, 8'd0, 1'b1);
    step(1'b0, 2'd0, 8'd0, 1'b1);
    tag_ovr = "R2";
    for (int k = 0; k < 40; k++) step(1'b0, 2'd0, 8'd0, 1'b0);
    for (int k = 0; k < 12; k++) step(1'b0, 2'd0, 8'd0, 1'b1);
    tag_ovr = "";

    // R7 buffered writes while running, left then center
    for (int ctr = 0; ctr < 2; ctr++) begin
      cfg(4, 1, 1'b0, ctr[0], 2'd1);
      step(1'b0, 2'd0, 8'd0, 1'b1);
      tag_ovr = "R7";
      step(1'b1, 2'd0, 8'd6, 1'b0);
      step(1'b1, 2'd1, 8'd3, 1'b0);
      for (int k = 0; k < 30; k++) step(1'b0, 2'd0, 8'd0, 1'b1);
      tag_ovr = "";
    end

    // R7 writes while disabled copy straight through
    cfg(3, 2, 1'b1, 1'b0, 2'd0);
    step(1'b1, 2'd2, 8'h02, 1'b0);
    tag_ovr = "R7";
    step(1'b1, 2'd1, 8'd1, 1'b1);
    step(1'b1, 2'd2, 8'h03, 1'b0);
    for (int k = 0; k < 9; k++) step(1'b0, 2'd0, 8'd0, 1'b1);

    // R1 reserved address write ignored
    tag_ovr = "R1";
    step(1'b1, 2'd3, 8'hFF, 1'b1);
    for (int k = 0; k < 9; k++) step(1'b0, 2'd0, 8'd0, 1'b1);

    // R8 disable mid-period returns to idle level
    tag_ovr = "R8";
    step(1'b1, 2'd2, 8'h02, 1'b1);
    for (int k = 0; k < 6; k++) step(1'b0, 2'd0, 8'd0, 1'b1);
    tag_ovr = "";

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule